// File: doc/BRIEF.md
# Translation Quadrant Context Decoder

This block sits at the front of an address translation path. For each request it takes a 64-bit effective address, the privilege mode (hypervisor or guest), the kind of access, and the current partition and process identifiers. It works out which partition and process context the rest of the translation must use. The two top address bits select one of four quadrants, and the meaning of each quadrant changes with the mode.

Before any context is chosen, the block checks a band of reserved address bits that sits just below the quadrant bits. If any bit in that band is set, or if a guest request targets one of the two quadrants that guests may not use, the request takes a segment fault and no context is produced. A fault is then classed as an instruction fault or a data fault. For data faults the faulting address is passed on.

All results are registered. They appear one cycle after an input strobe, together with an output valid pulse.

Top module: `qd_ctx_decoder`

## Requirements
- R1: If any of address bits 61:52 is nonzero, the request takes a segment fault and both context outputs are zero, in either mode.
- R2: In hypervisor mode, quadrant 0 (address bits 63:62 = 00) yields partition 0 and the current process identifier.
- R3: In hypervisor mode, quadrant 1 (bits 63:62 = 01) yields the current partition identifier and the current process identifier.
- R4: In hypervisor mode, quadrant 2 (bits 63:62 = 10) yields the current partition identifier and process 0.
- R5: In hypervisor mode, quadrant 3 (bits 63:62 = 11) yields partition 0 and process 0.
- R6: In guest mode, quadrant 0 (application space) yields the current partition identifier and the current process identifier.
- R7: In guest mode, quadrant 3 (system space) yields the current partition identifier and process 0.
- R8: In guest mode, quadrants 1 and 2 take a segment fault with zero context outputs.
- R9: A faulting instruction fetch (access code 00) sets the instruction-fault flag, clears the data-fault flag and gives a fault address of zero.
- R10: A faulting load (code 01), store (code 10) or code 11 (handled as a load) sets the data-fault flag, clears the instruction-fault flag and gives the full effective address as the fault address.
- R11: A request that does not fault clears both fault flags and gives a fault address of zero.
- R12: out_valid is high exactly in the cycle after a cycle with in_valid high. The result outputs change only after a strobe and hold their values otherwise.
- R13: While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| ea | input | 64 | Effective address |
| hv_mode | input | 1 | 1 = hypervisor mode, 0 = guest mode |
| acc | input | 2 | Access kind: 00 fetch, 01 load, 10 store, 11 handled as load |
| cur_lpid | input | 12 | Current partition identifier |
| cur_pid | input | 20 | Current process identifier |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| ctx_lpid | output | 12 | Selected partition identifier |
| ctx_pid | output | 20 | Selected process identifier |
| seg_fault | output | 1 | Segment fault raised |
| fault_inst | output | 1 | Fault is an instruction segment fault |
| fault_data | output | 1 | Fault is a data segment fault |
| fault_addr | output | 64 | Faulting address for data faults, otherwise zero |

## Verification
The bound checker checks several rules on every cycle:
- the one-cycle valid latency;
- zero context on any fault;
- exactly one fault class per fault;
- clear flags and a zero address when there is no fault;
- faults from the reserved band and from illegal guest quadrants;
- the context choices for hypervisor quadrants 0 and 3;
- the data-fault address.

The full quadrant-by-mode mapping, with both identifiers at the same time, is shown only by the bench's vector table. The same holds for the edge bits of the reserved band, for access code 11, for holding the outputs between strobes, and for clearing on a reset in mid-run.

// File: rtl/qd_pkg.sv
package qd_pkg;
   typedef enum logic [1:0] {
      ACC_FETCH = 2'b00,
      ACC_LOAD  = 2'b01,
      ACC_STORE = 2'b10,
      ACC_OTHER = 2'b11
   } acc_e;

   typedef struct packed {
      logic use_lpid;
      logic use_pid;
      logic illegal;
   } qsel_t;
endpackage

// File: rtl/qd_quad_map.sv
module qd_quad_map
   import qd_pkg::*;
(
   input  logic [1:0] quad,
   input  logic       hv,
   output qsel_t      sel
);
   always_comb begin
      sel = '0;
      if (hv) begin
         unique case (quad)
            2'd0: sel = '{use_lpid: 1'b0, use_pid: 1'b1, illegal: 1'b0};
            2'd1: sel = '{use_lpid: 1'b1, use_pid: 1'b1, illegal: 1'b0};
            2'd2: sel = '{use_lpid: 1'b1, use_pid: 1'b0, illegal: 1'b0};
            default: sel = '{use_lpid: 1'b0, use_pid: 1'b0, illegal: 1'b0};
         endcase
      end else begin
         unique case (quad)
            2'd0: sel = '{use_lpid: 1'b1, use_pid: 1'b1, illegal: 1'b0};
            2'd3: sel = '{use_lpid: 1'b1, use_pid: 1'b0, illegal: 1'b0};
            default: sel = '{use_lpid: 1'b0, use_pid: 1'b0, illegal: 1'b1};
         endcase
      end
   end
endmodule

// File: rtl/qd_rsv_check.sv
module qd_rsv_check #(
   parameter int BAND_W    = 10,
   parameter bit CHECK_RSV = 1'b1
) (
   input  logic [BAND_W-1:0] band,
   output logic              bad
);
   generate
      if (CHECK_RSV) begin : g_check
         assign bad = |band;
      end else begin : g_nocheck
         assign bad = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/qd_fault_rpt.sv
module qd_fault_rpt
   import qd_pkg::*;
#(
   parameter int EA_W = 64
) (
   input  logic            fault,
   input  logic [1:0]      acc,
   input  logic [EA_W-1:0] ea,
   output logic            is_inst,
   output logic            is_data,
   output logic [EA_W-1:0] addr
);
   logic fetch;
   assign fetch   = (acc == ACC_FETCH);
   assign is_inst = fault & fetch;
   assign is_data = fault & ~fetch;
   assign addr    = is_data ? ea : '0;
endmodule

// File: rtl/qd_ctx_decoder.sv
module qd_ctx_decoder
   import qd_pkg::*;
#(
   parameter int EA_W      = 64,
   parameter int LPID_W    = 12,
   parameter int PID_W     = 20,
   parameter int RSV_LO    = 52,
   parameter bit CHECK_RSV = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [EA_W-1:0]   ea,
   input  logic              hv_mode,
   input  logic [1:0]        acc,
   input  logic [LPID_W-1:0] cur_lpid,
   input  logic [PID_W-1:0]  cur_pid,
   output logic              out_valid,
   output logic [LPID_W-1:0] ctx_lpid,
   output logic [PID_W-1:0]  ctx_pid,
   output logic              seg_fault,
   output logic              fault_inst,
   output logic              fault_data,
   output logic [EA_W-1:0]   fault_addr
);
   localparam int RSV_HI = EA_W - 3;
   localparam int BAND_W = RSV_HI - RSV_LO + 1;

   generate
      if (EA_W < 8)                     begin : g_bad_ea  $error("EA_W too small");       end
      if (RSV_LO < 0 || RSV_LO > RSV_HI) begin : g_bad_rsv $error("RSV_LO out of range"); end
      if (LPID_W < 1 || PID_W < 1)      begin : g_bad_id  $error("ID widths must be >0"); end
   endgenerate

   qsel_t            sel;
   logic             rsv_bad;
   logic             fault;
   logic             n_inst, n_data;
   logic [EA_W-1:0]  n_addr;
   logic [LPID_W-1:0] n_lpid;
   logic [PID_W-1:0]  n_pid;

   qd_quad_map u_map (
      .quad (ea[EA_W-1 -: 2]),
      .hv   (hv_mode),
      .sel  (sel)
   );

   qd_rsv_check #(.BAND_W(BAND_W), .CHECK_RSV(CHECK_RSV)) u_rsv (
      .band (ea[RSV_HI:RSV_LO]),
      .bad  (rsv_bad)
   );

   assign fault  = rsv_bad | sel.illegal;
   assign n_lpid = (!fault && sel.use_lpid) ? cur_lpid : '0;
   assign n_pid  = (!fault && sel.use_pid)  ? cur_pid  : '0;

   qd_fault_rpt #(.EA_W(EA_W)) u_rpt (
      .fault   (fault),
      .acc     (acc),
      .ea      (ea),
      .is_inst (n_inst),
      .is_data (n_data),
      .addr    (n_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         ctx_lpid   <= '0;
         ctx_pid    <= '0;
         seg_fault  <= 1'b0;
         fault_inst <= 1'b0;
         fault_data <= 1'b0;
         fault_addr <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            ctx_lpid   <= n_lpid;
            ctx_pid    <= n_pid;
            seg_fault  <= fault;
            fault_inst <= n_inst;
            fault_data <= n_data;
            fault_addr <= n_addr;
         end
      end
   end
endmodule

// File: rtl/qd_ctx_checker.sv
module qd_ctx_checker #(
   parameter int EA_W   = 64,
   parameter int LPID_W = 12,
   parameter int PID_W  = 20,
   parameter int RSV_LO = 52
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [EA_W-1:0]   ea,
   input logic              hv_mode,
   input logic [1:0]        acc,
   input logic [LPID_W-1:0] cur_lpid,
   input logic [PID_W-1:0]  cur_pid,
   input logic              out_valid,
   input logic [LPID_W-1:0] ctx_lpid,
   input logic [PID_W-1:0]  ctx_pid,
   input logic              seg_fault,
   input logic              fault_inst,
   input logic              fault_data,
   input logic [EA_W-1:0]   fault_addr
);
   logic       band_set;
   logic [1:0] q;
   assign band_set = |ea[EA_W-3:RSV_LO];
   assign q        = ea[EA_W-1 -: 2];

   p_valid_lat_r12: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_no_spur_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_band_fault_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && band_set) |=> (seg_fault && ctx_lpid == '0 && ctx_pid == '0));
   p_guest_illegal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !hv_mode && (q == 2'd1 || q == 2'd2)) |=> seg_fault);
   p_hv_q0_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && hv_mode && q == 2'd0 && !band_set) |=>
      (!seg_fault && ctx_lpid == '0 && ctx_pid == $past(cur_pid)));
   p_hv_q3_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && hv_mode && q == 2'd3 && !band_set) |=>
      (!seg_fault && ctx_lpid == '0 && ctx_pid == '0));
   p_one_class_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && seg_fault) |-> $onehot({fault_inst, fault_data}));
   p_data_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && acc != 2'b00) |=> (seg_fault == fault_data) &&
      (!fault_data || fault_addr == $past(ea)));
   p_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !seg_fault) |-> (!fault_inst && !fault_data && fault_addr == '0));
   p_fault_ctx_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && seg_fault) |-> (ctx_lpid == '0 && ctx_pid == '0));
endmodule

bind qd_ctx_decoder qd_ctx_checker #(
   .EA_W(EA_W), .LPID_W(LPID_W), .PID_W(PID_W), .RSV_LO(RSV_LO)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ea(ea), .hv_mode(hv_mode),
   .acc(acc), .cur_lpid(cur_lpid), .cur_pid(cur_pid), .out_valid(out_valid),
   .ctx_lpid(ctx_lpid), .ctx_pid(ctx_pid), .seg_fault(seg_fault),
   .fault_inst(fault_inst), .fault_data(fault_data), .fault_addr(fault_addr)
);

// File: tb/sim_qd_ctx_decoder.sv
`timescale 1ns/1ps
module sim_qd_ctx_decoder;
   localparam logic [11:0] CUR_L = 12'hA5C;
   localparam logic [19:0] CUR_P = 20'h12345;
   localparam int NV = 13;

   // vector table: ea, hv, acc, expected fault, expects current lpid, expects current pid
   localparam logic [63:0] V_EA [NV] = '{
      64'h0000_0000_0000_1000, 64'h4000_0000_0000_2000, 64'h8000_0000_0000_3000,
      64'hC000_0000_0000_4000, 64'h0000_0000_0000_5000, 64'hC00F_FFFF_FFFF_FFF8,
      64'h4000_0000_0000_6000, 64'h8000_0000_0000_7000, 64'h0010_0000_0000_0000,
      64'h2000_0000_0000_0000, 64'hC080_0000_0000_0040, 64'h0000_0000_0000_0000,
      64'h4000_0000_0000_0123 };
   localparam logic       V_HV [NV] = '{1,1,1,1,0,0,0,0,1,1,0,0,0};
   localparam logic [1:0] V_AC [NV] = '{2'd1,2'd1,2'd2,2'd0,2'd1,2'd0,2'd1,2'd0,2'd2,2'd0,2'd1,2'd3,2'd3};
   localparam logic       V_F  [NV] = '{0,0,0,0,0,0,1,1,1,1,1,0,1};
   localparam logic       V_L  [NV] = '{0,1,1,0,1,1,0,0,0,0,0,1,0};
   localparam logic       V_P  [NV] = '{1,1,0,0,1,0,0,0,0,0,0,1,0};
   localparam string      V_T  [NV] = '{"R2","R3","R4","R5","R6","R7","R8 R10","R8 R9",
                                        "R1 R10","R1 R9","R1 R10","R6 R11","R8 R10"};

   logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, hv_mode = 1'b0;
   logic [63:0] ea = '0;
   logic [1:0]  acc = '0;
   logic [11:0] cur_lpid = CUR_L;
   logic [19:0] cur_pid = CUR_P;
   logic out_valid, seg_fault, fault_inst, fault_data;
   logic [11:0] ctx_lpid;
   logic [19:0] ctx_pid;
   logic [63:0] fault_addr;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   qd_ctx_decoder u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ea(ea), .hv_mode(hv_mode),
      .acc(acc), .cur_lpid(cur_lpid), .cur_pid(cur_pid), .out_valid(out_valid),
      .ctx_lpid(ctx_lpid), .ctx_pid(ctx_pid), .seg_fault(seg_fault),
      .fault_inst(fault_inst), .fault_data(fault_data), .fault_addr(fault_addr)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_vec(input int i);
      logic exp_i, exp_d;
      @(negedge clk);
      ea = V_EA[i]; hv_mode = V_HV[i]; acc = V_AC[i]; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      exp_i = V_F[i] && V_AC[i] == 2'd0;
      exp_d = V_F[i] && V_AC[i] != 2'd0;
      chk({V_T[i], " R12 valid"}, {63'd0, out_valid}, 64'd1);
      chk({V_T[i], " fault"},     {63'd0, seg_fault}, {63'd0, V_F[i]});
      chk({V_T[i], " lpid"},      {52'd0, ctx_lpid}, V_L[i] ? {52'd0, CUR_L} : 64'd0);
      chk({V_T[i], " pid"},       {44'd0, ctx_pid},  V_P[i] ? {44'd0, CUR_P} : 64'd0);
      chk({V_T[i], " inst"},      {63'd0, fault_inst}, {63'd0, exp_i});
      chk({V_T[i], " data"},      {63'd0, fault_data}, {63'd0, exp_d});
      chk({V_T[i], " addr"},      fault_addr, exp_d ? V_EA[i] : 64'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R13: reset state
      chk("R13 valid", {63'd0, out_valid}, 64'd0);
      chk("R13 ctx", {32'd0, ctx_lpid, ctx_pid}, 64'd0);
      chk("R13 flags", {61'd0, seg_fault, fault_inst, fault_data}, 64'd0);
      chk("R13 addr", fault_addr, 64'd0);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) run_vec(i);

      // R12: outputs hold while no strobe, even when inputs change
      run_vec(1);
      ea = 64'h8000_0000_0000_0000; hv_mode = 1'b0; acc = 2'd1;
      @(negedge clk);
      chk("R12 no valid", {63'd0, out_valid}, 64'd0);
      chk("R12 hold lpid", {52'd0, ctx_lpid}, {52'd0, CUR_L});
      chk("R12 hold pid", {44'd0, ctx_pid}, {44'd0, CUR_P});
      chk("R12 hold fault", {63'd0, seg_fault}, 64'd0);

      // R12: back-to-back strobes, second result follows the first by one cycle
      ea = 64'hC000_0000_0000_0000; hv_mode = 1'b1; acc = 2'd0; in_valid = 1'b1;
      @(negedge clk);
      ea = 64'h4000_0000_0000_0010; hv_mode = 1'b0; acc = 2'd2;
      chk("R5 b2b first", {32'd0, ctx_lpid, ctx_pid}, 64'd0);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R12 b2b valid", {63'd0, out_valid}, 64'd1);
      chk("R10 b2b addr", fault_addr, 64'h4000_0000_0000_0010);

      // R13: reset in mid-run clears a faulted result
      rst_n = 1'b0;
      @(negedge clk);
      chk("R13 midrun", {60'd0, out_valid, seg_fault, fault_data, fault_inst}, 64'd0);
      chk("R13 midrun addr", fault_addr, 64'd0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule